// File: doc/BRIEF.md
# Transfer Descriptor Status Updater

This block folds the outcome of one bus transaction into the control/status word of a USB transfer descriptor. It takes that word and the descriptor's token word, a three-bit transaction result and the byte count that moved. On a one-cycle strobe it computes the word to write back to memory. The result is registered, so it appears one cycle after the strobe together with a done pulse. With that pulse come three flags: one when the descriptor has retired, one that requests an interrupt, and one that marks a short input packet.

The block sits between a transaction engine and the logic that writes descriptors back to memory. It handles one descriptor per strobe and keeps no state between descriptors apart from its output register. Error status bits in the word are sticky: a bit set by an earlier transaction stays set. A two-bit retry counter in the word counts down on transmission errors and forces a stall when it runs out.

Top module: `td_status_updater`

## Requirements
- R1: While reset is held (synchronous, active low), `status_out` is zero and `upd_done`, `td_complete`, `td_irq` and `td_short` are low.
- R2: `upd_done` pulses high exactly one cycle after each `upd_strobe`. `status_out` changes only in that cycle. If the Active bit (bit 23) of `ctrl_in` is clear, the word is echoed unchanged and `td_complete` stays low.
- R3: With result 0 (success), Active is cleared and `td_complete` is high. The actual-length field (bits 10:0) is written as byte count minus one in 11 bits, so zero bytes gives 0x7FF.
- R4: With result 1 (NAK), the NAK bit (19) is set, Active stays set and the error counter (bits 28:27) is unchanged.
- R5: Three results each set their own bit: 3 (CRC/timeout) sets bit 18, 6 (bit-stuff) sets bit 17 and 5 (buffer error) sets bit 21. Each one also decrements a nonzero error counter. When the counter goes from 1 to 0, Active is cleared and Stalled (bit 22) is set. Otherwise Active stays set. The counter never rises.
- R6: An error counter of zero means unlimited retries. An error result then leaves the counter at zero and Active set.
- R7: Result 2 (stall) and the reserved result 7 clear Active and set Stalled. Result 4 (babble) does the same and also sets Babble (bit 20). None of them changes the counter.
- R8: If the token PID (token bits 7:0) is not 0x69, 0xE1 or 0x2D, Active is cleared, Stalled is set and the length field becomes 0x7FF, whatever the result.
- R9: `td_irq` is high exactly when `td_complete` is high and bit 24 of the input word is set.
- R10: `td_short` is high only in one case: a successful transfer with PID 0x69, bit 29 set, and a byte count below the maximum length. The maximum length is token bits 31:21 plus one, and 0x7FF means zero bytes.
- R11: Status bits already set in bits 22:17 are kept. Bits 31:29, 26:24 and 16:11 pass through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| upd_strobe | input | 1 | One-cycle request to update a descriptor |
| ctrl_in | input | 32 | Current control/status word |
| token_in | input | 32 | Token word (max length, address, PID) |
| result_in | input | 3 | Transaction result code |
| xfer_bytes | input | LEN_W | Bytes actually transferred |
| status_out | output | 32 | Updated control/status word |
| upd_done | output | 1 | Result valid, one cycle after the strobe |
| td_complete | output | 1 | Descriptor retired (Active cleared by this update) |
| td_irq | output | 1 | Completion interrupt request |
| td_short | output | 1 | Short input packet detected |

## Verification
The assertions take for granted that `upd_strobe` is a clean single-cycle pulse and that the inputs are stable while it is high. The counter assertion also assumes that the input word's error field is meaningful at the strobe. The bench drives every request at the falling edge for exactly one cycle, with idle cycles between requests. It limits byte counts to the 11-bit length range. Result codes and PIDs, including the reserved code and an illegal PID, are chosen on purpose to reach each branch of the update.

// File: rtl/tdsu_pkg.sv
// Package: shared encodings for the descriptor status updater.
// Assumes the 32-bit control/status word layout used by the descriptor format.
package tdsu_pkg;
    localparam int WORD_W   = 32;
    localparam int POS_ACT  = 23;
    localparam int POS_IOC  = 24;
    localparam int POS_SPD  = 29;
    localparam int ERR_LO   = 27;
    localparam int FLAG_LO  = 17;
    localparam int FLAG_W   = 7;
    localparam int PID_W    = 8;
    localparam int TOK_MAXLO = 21;

    localparam logic [PID_W-1:0] PID_IN    = 8'h69;
    localparam logic [PID_W-1:0] PID_OUT   = 8'hE1;
    localparam logic [PID_W-1:0] PID_SETUP = 8'h2D;

    typedef enum logic [2:0] {
        RES_OK       = 3'd0,
        RES_NAK      = 3'd1,
        RES_STALL    = 3'd2,
        RES_CRC      = 3'd3,
        RES_BABBLE   = 3'd4,
        RES_BUFERR   = 3'd5,
        RES_BITSTUFF = 3'd6,
        RES_RSVD     = 3'd7
    } tdsu_result_e;

    // Status flag group, bits 23:17 of the word, MSB first.
    typedef struct packed {
        logic active;
        logic stalled;
        logic buferr;
        logic babble;
        logic nak;
        logic crc;
        logic bitstuff;
    } tdsu_flags_t;
endpackage

// File: rtl/tdsu_token_check.sv
// Module: decodes the token fields the updater needs.
// Flags whether the PID is one of the three legal ones and whether it is IN,
// and turns the n-1 max-length code into a byte count (all-ones -> 0).
module tdsu_token_check
    import tdsu_pkg::*;
#(
    parameter int LEN_W = 11
) (
    input  logic [LEN_W-1:0] max_code,
    input  logic [PID_W-1:0] pid,
    output logic             pid_legal,
    output logic             pid_is_in,
    output logic [LEN_W:0]   max_bytes
);
    // Classify the PID.
    always_comb begin
        pid_is_in = (pid == PID_IN);
        pid_legal = pid_is_in || (pid == PID_OUT) || (pid == PID_SETUP);
    end

    // Decode the n-1 length code; the all-ones code means zero bytes.
    always_comb begin
        if (&max_code) max_bytes = '0;
        else           max_bytes = {1'b0, max_code} + 1'b1;
    end
endmodule

// File: rtl/tdsu_len_codec.sv
// Module: encodes the actual byte count in the n-1 form and compares it
// against the decoded maximum. Assumes count fits in LEN_W bits.
module tdsu_len_codec #(
    parameter int LEN_W = 11
) (
    input  logic [LEN_W-1:0] count,
    input  logic [LEN_W:0]   max_bytes,
    output logic [LEN_W-1:0] len_code,
    output logic             below_max
);
    // n-1 encoding wraps zero bytes onto the all-ones code.
    always_comb len_code = count - 1'b1;

    // Short-transfer comparison on the widened count.
    always_comb below_max = ({1'b0, count} < max_bytes);
endmodule

// File: rtl/tdsu_err_step.sv
// Module: applies one transaction result to the sticky flag group and the
// retry counter. Assumes the caller has already checked that the descriptor
// is active and its PID legal. A counter of zero means unlimited retries.
module tdsu_err_step
    import tdsu_pkg::*;
#(
    parameter int CNT_W = 2
) (
    input  tdsu_flags_t      flags_in,
    input  logic [CNT_W-1:0] cnt_in,
    input  tdsu_result_e     result,
    output tdsu_flags_t      flags_out,
    output logic [CNT_W-1:0] cnt_out
);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic counted;

    // Mark results that consume a retry.
    always_comb counted = (result == RES_CRC) || (result == RES_BITSTUFF) ||
                          (result == RES_BUFERR);

    // Update flags and counter from the result.
    always_comb begin
        flags_out = flags_in;
        cnt_out   = cnt_in;
        case (result)
            RES_OK:       flags_out.active = 1'b0;
            RES_NAK:      flags_out.nak    = 1'b1;
            RES_BABBLE: begin
                flags_out.babble  = 1'b1;
                flags_out.active  = 1'b0;
                flags_out.stalled = 1'b1;
            end
            RES_STALL, RES_RSVD: begin
                flags_out.active  = 1'b0;
                flags_out.stalled = 1'b1;
            end
            RES_CRC:      flags_out.crc      = 1'b1;
            RES_BITSTUFF: flags_out.bitstuff = 1'b1;
            RES_BUFERR:   flags_out.buferr   = 1'b1;
            default:      flags_out = flags_in;
        endcase
        if (counted && (cnt_in != '0)) begin
            cnt_out = cnt_in - 1'b1;
            if (cnt_in == CNT_ONE) begin
                flags_out.active  = 1'b0;
                flags_out.stalled = 1'b1;
            end
        end
    end
endmodule

// File: rtl/td_status_updater.sv
// Module: top of the descriptor status updater. On upd_strobe it merges one
// transaction result into the control/status word and registers the new word
// with done/complete/irq/short flags one cycle later.
// Assumes upd_strobe is a single-cycle pulse with stable inputs.
module td_status_updater
    import tdsu_pkg::*;
#(
    parameter int LEN_W = 11,
    parameter int CNT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_strobe,
    input  logic [WORD_W-1:0] ctrl_in,
    input  logic [WORD_W-1:0] token_in,
    input  logic [2:0]        result_in,
    input  logic [LEN_W-1:0]  xfer_bytes,
    output logic [WORD_W-1:0] status_out,
    output logic              upd_done,
    output logic              td_complete,
    output logic              td_irq,
    output logic              td_short
);
    localparam int ERR_HI  = ERR_LO + CNT_W - 1;
    localparam int FLAG_HI = FLAG_LO + FLAG_W - 1;
    localparam int TOK_MAXHI = TOK_MAXLO + LEN_W - 1;

    tdsu_result_e     res;
    logic             pid_legal, pid_is_in, below_max;
    logic [LEN_W:0]   max_bytes;
    logic [LEN_W-1:0] len_code;
    tdsu_flags_t      flags_new;
    logic [CNT_W-1:0] cnt_new;
    logic [WORD_W-1:0] next_word;
    logic             complete_d, irq_d, short_d;
    logic             tok_unused;

    logic [WORD_W-1:0] status_q;
    logic             done_q, complete_q, irq_q, short_q;

    // Cast the raw result code onto the enum.
    always_comb res = tdsu_result_e'(result_in);

    // Token fields not used by the update (toggle, endpoint, address).
    always_comb tok_unused = ^token_in[TOK_MAXLO-1:PID_W];

    tdsu_token_check #(.LEN_W(LEN_W)) u_tok (
        .max_code  (token_in[TOK_MAXHI:TOK_MAXLO]),
        .pid       (token_in[PID_W-1:0]),
        .pid_legal (pid_legal),
        .pid_is_in (pid_is_in),
        .max_bytes (max_bytes)
    );

    tdsu_len_codec #(.LEN_W(LEN_W)) u_len (
        .count     (xfer_bytes),
        .max_bytes (max_bytes),
        .len_code  (len_code),
        .below_max (below_max)
    );

    tdsu_err_step #(.CNT_W(CNT_W)) u_err (
        .flags_in  (tdsu_flags_t'(ctrl_in[FLAG_HI:FLAG_LO])),
        .cnt_in    (ctrl_in[ERR_HI:ERR_LO]),
        .result    (res),
        .flags_out (flags_new),
        .cnt_out   (cnt_new)
    );

    // Compose the write-back word and the per-update flags.
    always_comb begin
        next_word = ctrl_in;
        if (ctrl_in[POS_ACT]) begin
            if (!pid_legal) begin
                next_word[POS_ACT]     = 1'b0;
                next_word[POS_ACT-1]   = 1'b1;
                next_word[LEN_W-1:0]   = '1;
            end else begin
                next_word[FLAG_HI:FLAG_LO] = flags_new;
                next_word[ERR_HI:ERR_LO]   = cnt_new;
                next_word[LEN_W-1:0]       = len_code;
            end
        end
        complete_d = ctrl_in[POS_ACT] & ~next_word[POS_ACT];
        irq_d      = complete_d & ctrl_in[POS_IOC];
        short_d    = ctrl_in[POS_ACT] & pid_legal & pid_is_in &
                     (res == RES_OK) & ctrl_in[POS_SPD] & below_max;
    end

    // Output register: word held between updates, flags pulse with done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q   <= '0;
            done_q     <= 1'b0;
            complete_q <= 1'b0;
            irq_q      <= 1'b0;
            short_q    <= 1'b0;
        end else begin
            done_q <= upd_strobe;
            if (upd_strobe) begin
                status_q   <= next_word;
                complete_q <= complete_d;
                irq_q      <= irq_d;
                short_q    <= short_d;
            end else begin
                complete_q <= 1'b0;
                irq_q      <= 1'b0;
                short_q    <= 1'b0;
            end
        end
    end

    always_comb begin
        status_out  = status_q;
        upd_done    = done_q;
        td_complete = complete_q;
        td_irq      = irq_q;
        td_short    = short_q;
    end

    // R2
    done_follows_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_strobe |=> upd_done);
    // R2
    word_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_strobe |=> ($stable(status_out) && !upd_done));
    // R3
    complete_clears_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        td_complete |-> (upd_done && !status_out[POS_ACT]));
    // R5
    errcnt_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_done |-> (status_out[ERR_HI:ERR_LO] <= $past(ctrl_in[ERR_HI:ERR_LO])));
    // R9
    irq_needs_complete_chk: assert property (@(posedge clk) disable iff (!rst_n)
        td_irq |-> (td_complete && status_out[POS_IOC]));
    // R10
    short_needs_complete_chk: assert property (@(posedge clk) disable iff (!rst_n)
        td_short |-> td_complete);
endmodule

// File: tb/td_status_updater_test.sv
module td_status_updater_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYC = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        upd_strobe = 1'b0;
    logic [31:0] ctrl_in = '0;
    logic [31:0] token_in = '0;
    logic [2:0]  result_in = '0;
    logic [10:0] xfer_bytes = '0;
    logic [31:0] status_out;
    logic        upd_done, td_complete, td_irq, td_short;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    logic [34:0] exp_q[$];
    string       tag_q[$];
    logic [31:0] last_word = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    td_status_updater uut (
        .clk(clk), .rst_n(rst_n), .upd_strobe(upd_strobe),
        .ctrl_in(ctrl_in), .token_in(token_in), .result_in(result_in),
        .xfer_bytes(xfer_bytes), .status_out(status_out), .upd_done(upd_done),
        .td_complete(td_complete), .td_irq(td_irq), .td_short(td_short)
    );

    // Word builder: spd, error count, ioc, active, sticky flags 22:17, passthrough bits 15:11.
    function automatic logic [31:0] mkw(input bit spd, input logic [1:0] ec, input bit ioc,
                                         input bit act, input logic [5:0] st, input logic [4:0] mid);
        return {2'b10, spd, ec, 1'b0, 1'b0, ioc, act, st, 1'b0, mid, 11'h7FF};
    endfunction

    function automatic logic [31:0] mkt(input logic [10:0] maxc, input logic [7:0] pid);
        return {maxc, 6'h0, 7'h05, pid};
    endfunction

    // Expected result from the requirements: {word, complete, irq, short}.
    function automatic logic [34:0] model(input logic [31:0] c, input logic [31:0] t,
                                          input int r, input logic [10:0] n);
        logic [31:0] w = c;
        bit legal, cmp, ir, sh;
        int ec, maxb;
        legal = (t[7:0] == 8'h69) || (t[7:0] == 8'hE1) || (t[7:0] == 8'h2D);
        ec = int'(c[28:27]);
        maxb = (t[31:21] == 11'h7FF) ? 0 : int'(t[31:21]) + 1;
        sh = 0;
        if (c[23]) begin
            if (!legal) begin
                w[23] = 0; w[22] = 1; w[10:0] = 11'h7FF;
            end else begin
                w[10:0] = n - 11'd1;
                if (r == 0) w[23] = 0;
                else if (r == 1) w[19] = 1;
                else if (r == 2 || r == 7) begin w[23] = 0; w[22] = 1; end
                else if (r == 4) begin w[23] = 0; w[22] = 1; w[20] = 1; end
                else begin
                    if (r == 3) w[18] = 1;
                    if (r == 6) w[17] = 1;
                    if (r == 5) w[21] = 1;
                    if (ec == 1) begin w[23] = 0; w[22] = 1; end
                    if (ec != 0) w[28:27] = 2'(ec - 1);
                end
                sh = (r == 0) && (t[7:0] == 8'h69) && c[29] && (int'(n) < maxb);
            end
        end
        cmp = c[23] && !w[23];
        ir = cmp && c[24];
        return {w, cmp, ir, sh};
    endfunction

    task automatic send(input logic [31:0] c, input logic [31:0] t, input int r,
                        input logic [10:0] n, input string tag);
        @(negedge clk);
        ctrl_in = c; token_in = t; result_in = 3'(r); xfer_bytes = n; upd_strobe = 1'b1;
        exp_q.push_back(model(c, t, r, n));
        tag_q.push_back(tag);
        @(negedge clk);
        upd_strobe = 1'b0;
        @(negedge clk);
    endtask

    // Monitor: pop and compare each result in the cycle upd_done is high.
    always @(negedge clk) begin
        if (rst_n && upd_done) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R2: unexpected upd_done, actual=1 expected=0");
            end else begin
                logic [34:0] e;
                string tg;
                e = exp_q.pop_front();
                tg = tag_q.pop_front();
                last_word = e[34:3];
                if ({status_out, td_complete, td_irq, td_short} !== e) begin
                    errors++;
                    $display("FAIL %s: actual=%h/%b%b%b expected=%h/%b%b%b", tg,
                             status_out, td_complete, td_irq, td_short,
                             e[34:3], e[2], e[1], e[0]);
                end
            end
        end
    end

    initial begin
        repeat (WATCHDOG_CYC) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (status_out !== 32'h0 || upd_done || td_complete || td_irq || td_short) begin
            errors++;
            $display("FAIL R1: actual=%h/%b%b%b%b expected=0/0000", status_out,
                     upd_done, td_complete, td_irq, td_short);
        end
        rst_n = 1'b1;

        // R3 R9: full-length IN success with completion interrupt
        send(mkw(1, 2'd3, 1, 1, 6'h0, 5'h0), mkt(11'd7, 8'h69), 0, 11'd8, "R3/R9 full IN");
        // R3: zero-byte OUT success encodes 0x7FF
        send(mkw(0, 2'd2, 0, 1, 6'h0, 5'h0), mkt(11'h7FF, 8'hE1), 0, 11'd0, "R3 zero bytes");
        // R10: short IN with detect enabled
        send(mkw(1, 2'd3, 0, 1, 6'h0, 5'h0), mkt(11'd63, 8'h69), 0, 11'd3, "R10 short IN");
        // R10: short IN with detect disabled
        send(mkw(0, 2'd3, 1, 1, 6'h0, 5'h0), mkt(11'd63, 8'h69), 0, 11'd3, "R10 no detect");
        // R10: OUT never short
        send(mkw(1, 2'd3, 0, 1, 6'h0, 5'h0), mkt(11'd63, 8'h2D), 0, 11'd3, "R10 setup");
        // R4: NAK keeps Active and counter
        send(mkw(0, 2'd3, 1, 1, 6'h0, 5'h0), mkt(11'd7, 8'h69), 1, 11'd0, "R4 nak");
        // R5: CRC from 3 -> 2
        send(mkw(0, 2'd3, 1, 1, 6'h0, 5'h0), mkt(11'd7, 8'hE1), 3, 11'd2, "R5 crc dec");
        // R5: CRC from 1 -> stall
        send(mkw(0, 2'd1, 1, 1, 6'h0, 5'h0), mkt(11'd7, 8'hE1), 3, 11'd0, "R5 crc stall");
        // R5: bit-stuff from 2
        send(mkw(0, 2'd2, 0, 1, 6'h0, 5'h0), mkt(11'd7, 8'h69), 6, 11'd1, "R5 bitstuff");
        // R5: buffer error from 1
        send(mkw(0, 2'd1, 0, 1, 6'h0, 5'h0), mkt(11'd7, 8'h69), 5, 11'd4, "R5 buferr");
        // R6: unlimited retries
        send(mkw(0, 2'd0, 1, 1, 6'h0, 5'h0), mkt(11'd7, 8'h69), 3, 11'd0, "R6 unlimited");
        // R7: stall, babble, reserved code
        send(mkw(0, 2'd3, 1, 1, 6'h0, 5'h0), mkt(11'd7, 8'h69), 2, 11'd0, "R7 stall");
        send(mkw(0, 2'd2, 0, 1, 6'h0, 5'h0), mkt(11'd7, 8'h69), 4, 11'd9, "R7 babble");
        send(mkw(0, 2'd2, 1, 1, 6'h0, 5'h0), mkt(11'd7, 8'hE1), 7, 11'd1, "R7 reserved");
        // R8: illegal PID overrides a success result
        send(mkw(1, 2'd3, 1, 1, 6'h0, 5'h0), mkt(11'd7, 8'h55), 0, 11'd5, "R8 bad pid");
        // R2: inactive descriptor echoed
        send(mkw(1, 2'd2, 1, 0, 6'h15, 5'h1A), mkt(11'd7, 8'h69), 3, 11'd5, "R2 inactive");
        // R11: sticky bits and passthrough fields
        send(mkw(0, 2'd3, 0, 1, 6'h09, 5'h13), mkt(11'd31, 8'hE1), 0, 11'd32, "R11 sticky");
        send(mkw(1, 2'd2, 1, 1, 6'h22, 5'h0C), mkt(11'd31, 8'h69), 1, 11'd0, "R11 nak sticky");

        // R2: idle cycles leave the word held and done low
        repeat (3) @(negedge clk);
        checks++;
        if (upd_done || td_complete) begin
            errors++;
            $display("FAIL R2 idle: actual=%b%b expected=00", upd_done, td_complete);
        end
        checks++;
        if (status_out !== last_word) begin
            errors++;
            $display("FAIL R2 hold: actual=%h expected=%h", status_out, last_word);
        end
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R2 missing done: actual=%0d pending expected=0", exp_q.size());
        end
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule